// File: doc/BRIEF.md
# MDIO Station Management Master

This block runs one PHY register access on the two-wire management interface each time software writes its station register. The station register holds a 5-bit PHY address, a 5-bit register address and a direction bit. A second register holds 16 bits of data. A write access sends the data register to the addressed PHY register. A read access loads the PHY's answer into the data register.

The block divides the system clock by a programmable even divisor to make the management clock. It shifts out a complete frame MSB first: preamble, start, opcode, addresses, turnaround and data. It drives the data line only while it owns it. Software polls the busy bit to learn when the access has finished. The host side is a plain register port with a one-cycle write strobe and a combinational read mux, so there is no back-pressure on it. The PHY side is the two management pins.

Top module: `mdio_station_ctrl`

## Requirements
- R1: After reset the management clock is low, the data-line output enable is low, and both registers read 0. While the block is idle and was idle in the previous cycle, the clock and the output enable stay low.
- R2: A station-register write (reg_addr=0) accepted while idle starts an access. The busy bit (station bit 11) reads 1 from the next cycle, and it reads 1 for exactly 127*(clk_div/2) cycles.
- R3: The frame on the line has 64 bits, sent in this order: 32 ones, start 01, opcode (01 when station bit 10 is 1 for a write, 10 when it is 0 for a read), PHY address (station bits 9:5), register address (station bits 4:0), two turnaround bits, then 16 data bits, MSB first.
- R4: A write access drives turnaround as 10 and sends the value the data register (reg_addr=1) held when the access started. The data register keeps that value afterwards.
- R5: The management clock period is clk_div system cycles during a frame, high and low for clk_div/2 cycles each. The data line changes only in the cycle after a falling clock edge.
- R6: During a read, the output enable is high for frame bits 0..45 and low from the first turnaround bit (bit 46) to the end. During a write, it is high for all 64 bits.
- R7: When the PHY drives 0 on the second turnaround bit of a read, the 16 bits it returns are stored in the data register at completion.
- R8: When the PHY does not drive 0 on the second turnaround bit, the read stores 0xFFFF.
- R9: A station-register write while busy has no effect. This includes a write in the completion cycle itself. The station fields read back unchanged, and no new access starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Even management clock divisor (at least 2) |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 1 | 0 = station register, 1 = data register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The two events that can fall in the same cycle are the completion of an access and a new station-register write. In the completion cycle the busy bit is still set, so the write must be dropped. The bench computes the completion edge as 127*(clk_div/2) cycles after acceptance and places a conflicting station write exactly on that edge, and also one well inside the frame. It then judges the result at the ports: the station fields must read back unchanged, the busy bit must be clear, and the management clock must stay low with no second frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int ADR_W      = 5;
  localparam int DAT_W      = 16;
  localparam int PRE_BITS   = 32;
  localparam int TA1_POS    = PRE_BITS + 4 + 2 * ADR_W;
  localparam int TA2_POS    = TA1_POS + 1;
  localparam int DATA_POS   = TA2_POS + 1;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  localparam int ST_REG_LSB = 0;
  localparam int ST_PHY_LSB = ST_REG_LSB + ADR_W;
  localparam int ST_DIR_BIT = ST_PHY_LSB + ADR_W;
  localparam int ST_BSY_BIT = ST_DIR_BIT + 1;

  localparam logic ADDR_STA = 1'b0;
  localparam logic ADDR_DAT = 1'b1;

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic             is_wr,
      input logic [ADR_W-1:0] phy,
      input logic [ADR_W-1:0] rad,
      input logic [DAT_W-1:0] data);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DAT_W-1:0] d;
    op = is_wr ? 2'b01 : 2'b10;
    ta = is_wr ? 2'b10 : 2'b11;
    d  = is_wr ? data : '1;
    return {{PRE_BITS{1'b1}}, 2'b01, op, phy, rad, ta, d};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;
  logic             toggle;

  always_comb begin
    half   = (div < DIV_W'(2)) ? DIV_W'(1) : (div >> 1);
    toggle = en && (cnt == half - DIV_W'(1));
    rise   = toggle && !mdc;
    fall   = toggle && mdc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (toggle) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_wr,
  input  logic [ADR_W-1:0] phy,
  input  logic [ADR_W-1:0] rad,
  input  logic [DAT_W-1:0] wdata,
  input  logic             rise,
  input  logic             fall,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             done,
  output logic [DAT_W-1:0] rd_result
);
  logic [FRAME_BITS-1:0] sh;
  logic [CNT_W-1:0]      bitcnt;
  logic                  active;
  logic                  rd;
  logic                  ack;
  logic [DAT_W-1:0]      rxsh;

  assign mdio_o    = sh[FRAME_BITS-1];
  assign done      = active && rise && (bitcnt == CNT_W'(FRAME_BITS - 1));
  assign rd_result = ack ? {rxsh[DAT_W-2:0], mdio_i} : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      bitcnt  <= '0;
      active  <= 1'b0;
      rd      <= 1'b0;
      ack     <= 1'b0;
      rxsh    <= '0;
      mdio_oe <= 1'b0;
    end else if (start) begin
      sh      <= build_frame(is_wr, phy, rad, wdata);
      bitcnt  <= '0;
      active  <= 1'b1;
      rd      <= !is_wr;
      ack     <= 1'b0;
      mdio_oe <= 1'b1;
    end else if (active) begin
      if (fall) begin
        sh     <= sh << 1;
        bitcnt <= bitcnt + CNT_W'(1);
        if (rd && bitcnt == CNT_W'(TA1_POS - 1)) mdio_oe <= 1'b0;
      end
      if (rise) begin
        if (bitcnt == CNT_W'(TA2_POS)) ack <= !mdio_i;
        if (bitcnt >= CNT_W'(DATA_POS)) rxsh <= {rxsh[DAT_W-2:0], mdio_i};
        if (done) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
        end
      end
    end
  end

  assert_oe_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd && bitcnt >= CNT_W'(TA1_POS)) |-> !mdio_oe);

  assert_line_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(mdio_o)) |-> $past(fall));
endmodule

// File: rtl/mdio_station_ctrl.sv
module mdio_station_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic             busy;
  logic             st_dir;
  logic [ADR_W-1:0] st_phy;
  logic [ADR_W-1:0] st_reg;
  logic [DAT_W-1:0] data_q;
  logic             start;
  logic             done;
  logic             rise;
  logic             fall;
  logic [DAT_W-1:0] rd_result;

  assign start = reg_wr && (reg_addr == ADDR_STA) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      st_dir <= 1'b0;
      st_phy <= '0;
      st_reg <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      st_dir <= reg_wdata[ST_DIR_BIT];
      st_phy <= reg_wdata[ST_PHY_LSB +: ADR_W];
      st_reg <= reg_wdata[ST_REG_LSB +: ADR_W];
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) data_q <= '0;
    else if (done && !st_dir) data_q <= rd_result;
    else if (reg_wr && reg_addr == ADDR_DAT) data_q <= reg_wdata;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_DAT) begin
      reg_rdata = data_q;
    end else begin
      reg_rdata[ST_BSY_BIT]             = busy;
      reg_rdata[ST_DIR_BIT]             = st_dir;
      reg_rdata[ST_PHY_LSB +: ADR_W]    = st_phy;
      reg_rdata[ST_REG_LSB +: ADR_W]    = st_reg;
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (busy),
    .div  (clk_div),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  mdio_frame_engine u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_wr    (reg_wdata[ST_DIR_BIT]),
    .phy      (reg_wdata[ST_PHY_LSB +: ADR_W]),
    .rad      (reg_wdata[ST_REG_LSB +: ADR_W]),
    .wdata    (data_q),
    .rise     (rise),
    .fall     (fall),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .rd_result(rd_result)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!mdc && !mdio_oe));

  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && mdio_oe));

  assert_done_clears_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_busy_ignores_station_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == ADDR_STA) |=> $stable({st_dir, st_phy, st_reg}));
endmodule

// File: tb/mdio_station_ctrl_test.sv
`timescale 1ns/100ps
module mdio_station_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd2;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int total = 0;
  int bad = 0;

  // bench PHY model
  int          bitpos = 0;
  logic        phy_here = 1'b1;
  logic [15:0] resp = '0;
  logic        phy_drv;
  logic        line, line_q, oe_q;
  logic [63:0] cap = '0;
  bit          cur_rd = 1'b0;
  int          oe_bad = 0;
  int          per_bad = 0;
  time         last_rise = 0;

  always #2.5 clk = ~clk;

  mdio_station_ctrl #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always_comb begin
    phy_drv = 1'b1;
    if (bitpos == 47) phy_drv = ~phy_here;
    else if (bitpos >= 48 && bitpos <= 63) phy_drv = phy_here ? resp[63 - bitpos] : 1'b1;
  end
  assign line   = mdio_oe ? mdio_o : phy_drv;
  assign mdio_i = line;

  always @(negedge clk) begin
    line_q = line;
    oe_q   = mdio_oe;
  end
  always @(negedge mdc) bitpos = bitpos + 1;
  always @(posedge mdc) begin
    cap = {cap[62:0], line_q};
    if (cur_rd ? ((bitpos >= 46) == oe_q) : !oe_q) oe_bad++;
    if (last_rise != 0 && ($time - last_rise) != clk_div * 5) per_bad++;
    last_rise = $time;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  // one access; poke>0 issues a conflicting station write on that busy cycle
  task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d, input bit pres, input int poke);
    logic [15:0] sta, rb;
    logic [63:0] exp;
    int cnt, h;
    h = clk_div / 2;
    sta = {4'b0, 1'b0, wr, phy, rg};
    if (wr) begin
      bus_write(1'b1, d);
      bus_read(1'b1, rb);
      chk(rb == d, "R4 data register load", rb, d);
    end
    resp = d; phy_here = pres; cur_rd = !wr;
    bitpos = 0; cap = '0; oe_bad = 0; per_bad = 0; last_rise = 0;
    bus_write(1'b0, sta);
    cnt = 0;
    reg_addr = 1'b0;
    while (reg_rdata[11] && cnt < 5000) begin
      cnt++;
      if (poke > 0 && cnt == poke) begin
        reg_wr = 1'b1; reg_wdata = sta ^ 16'h07FF;
      end else reg_wr = 1'b0;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    chk(cnt == 127 * h, "R2 busy length", cnt, 127 * h);
    if (wr) exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
    else    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 1'b1, ~pres, pres ? d : 16'hFFFF};
    chk(cap == exp, wr ? "R4 write frame" : "R3 read frame", cap, exp);
    chk(oe_bad == 0, "R6 output enable window", oe_bad, 0);
    chk(per_bad == 0, "R5 clock period", per_bad, 0);
    bus_read(1'b1, rb);
    if (wr) chk(rb == d, "R4 data kept", rb, d);
    else if (pres) chk(rb == d, "R7 read result", rb, d);
    else chk(rb == 16'hFFFF, "R8 absent PHY", rb, 16'hFFFF);
    bus_read(1'b0, rb);
    chk(rb == sta, "R9 station fields", rb, sta);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_read(1'b0, rb);
    chk(rb == 0, "R1 station reset", rb, 0);
    bus_read(1'b1, rb);
    chk(rb == 0, "R1 data reset", rb, 0);
    chk({mdc, mdio_oe} == 2'b00, "R1 pins idle", {mdc, mdio_oe}, 0);

    clk_div = 8'd2;
    for (int r = 0; r < 32; r++)
      run_txn(1'b1, 5'(31 - r), 5'(r), 16'(r * 16'h0811) ^ 16'hA5C3, 1'b1, 0);

    clk_div = 8'd4;
    for (int r = 0; r < 32; r++)
      run_txn(1'b0, 5'(r), 5'(31 - r), ~16'(r * 16'h1357), (r % 3) != 0, 0);

    clk_div = 8'd6;
    run_txn(1'b1, 5'd5, 5'd17, 16'h8001, 1'b1, 0);
    run_txn(1'b0, 5'd9, 5'd2, 16'h0000, 1'b1, 0);
    run_txn(1'b0, 5'd1, 5'd30, 16'h7FFE, 1'b0, 0);

    // R9: conflicting station write mid-frame and on the completion edge
    clk_div = 8'd4;
    run_txn(1'b0, 5'd3, 5'd9, 16'h1234, 1'b1, 50);
    run_txn(1'b1, 5'd12, 5'd4, 16'hBEEF, 1'b1, 127 * 2);
    repeat (20) @(negedge clk);
    reg_addr = 1'b0;
    #0.5;
    chk({mdc, reg_rdata[11]} == 2'b00, "R9 no access after completion-cycle write",
        {mdc, reg_rdata[11]}, 0);
    chk(mdio_oe == 1'b0, "R1 idle enable low", mdio_oe, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule